// File: doc/BRIEF.md
# Rotate-Mask and Shift Unit

This unit performs the bit-field work of a 32-bit integer pipeline. It rotates a source word left and keeps only the bits under a mask. It can also rotate the source and merge it into the previous destination word under that mask. It does logical left, logical right and arithmetic right shifts as well.

The mask is given by two bit indices. Index 0 names the most significant bit. The mask covers every index from the begin index through the end index. When the begin index is greater than the end index, the mask wraps around the word.

Each accepted operation is computed combinationally and captured in an output register, so its result appears one cycle after it is issued. A record request asks for three condition flags, which compare the signed result with zero. The flags are registered together with the result.

Top module: `rms_unit`

## Requirements
- R1: Mask index i, where 0 is the MSB, selects result bit 31-i. When `mask_beg` <= `mask_end`, the mask covers every index from `mask_beg` through `mask_end`, both ends included.
- R2: When `mask_beg` > `mask_end`, the mask is the union of indices 0..`mask_end` and `mask_beg`..31.
- R3: Opcode 0 (rotate-and-mask) yields rotl(`src`, `amt[4:0]`) AND mask. `amt[5]` has no effect on it.
- R4: Opcode 1 (rotate-and-insert) yields (`dst_old` AND NOT mask) OR (rotl(`src`, `amt[4:0]`) AND mask).
- R5: Opcode 2 (shift left logical) yields 0 when `amt[5]` is 1. Otherwise it yields `src` shifted left by `amt[4:0]`, with zeros filling from the right.
- R6: Opcode 3 (shift right logical) yields 0 when `amt[5]` is 1. Otherwise it yields `src` shifted right by `amt[4:0]`, with zeros filling from the left.
- R7: Opcode 4 (shift right arithmetic) fills the vacated high bits with `src[31]`. When `amt[5]` is 1, every result bit equals `src[31]`.
- R8: A rotate by 0 with a full mask (begin 0, end 31) returns `src` unchanged.
- R9: An operation issued with `in_valid` at a rising edge appears on `result`, with `out_valid` high, after that edge. A cycle without `in_valid` gives `out_valid` low and leaves `result` unchanged.
- R10: `cond_valid` follows `rec_en` of the issued operation. `cond` is {negative, positive, zero}, comparing the signed result with zero, and exactly one of these bits is set. Without a record request, `cond_valid` is low.
- R11: While `rst_n` is low, `out_valid`, `cond_valid`, `result` and `cond` are all zero.
- R12: Opcodes 5, 6 and 7 yield a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 3 | Opcode 0..4, see requirements |
| src | input | 32 | Source word |
| dst_old | input | 32 | Previous destination word, used by insert |
| amt | input | 6 | Rotate or shift amount |
| mask_beg | input | 5 | Mask begin index (0 = MSB) |
| mask_end | input | 5 | Mask end index (0 = MSB) |
| rec_en | input | 1 | Request condition flags |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 32 | Registered result |
| cond_valid | output | 1 | Condition flags are valid |
| cond | output | 3 | {negative, positive, zero} of result |

## Verification
Two things happen in the same cycle. The output register presents one result and its flags, and a new operation is accepted at the input. The bench issues operations back to back and checks each result on the falling edge after its capture edge, before the next operation replaces it. An idle cycle after a burst proves that the previous value is held.

The record flags and the result of the same operation are registered together, and each pair is judged against a bench model. The bench sweeps every begin and end pair for both mask operations and every 6-bit amount for each shift.

// File: rtl/rms_unit.sv
`timescale 1ns/1ps
module rms_unit #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  dst_old,
  input  logic [SW:0]   amt,
  input  logic [SW-1:0] mask_beg,
  input  logic [SW-1:0] mask_end,
  input  logic          rec_en,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          cond_valid,
  output logic [2:0]    cond
);
  logic [W-1:0]   mask, rot, res;
  logic [2*W-1:0] dbl;
  logic [SW-1:0]  sh;
  logic           wrap, res_neg, res_zero;

  assign sh   = amt[SW-1:0];
  assign dbl  = {src, src} << sh;
  assign rot  = dbl[2*W-1:W];
  assign wrap = mask_beg > mask_end;

  for (genvar j = 0; j < W; j++) begin : g_mask
    localparam logic [SW-1:0] IDX = SW'(W - 1 - j);
    logic lo_ok, hi_ok;
    assign lo_ok   = IDX >= mask_beg;
    assign hi_ok   = IDX <= mask_end;
    assign mask[j] = wrap ? (lo_ok | hi_ok) : (lo_ok & hi_ok);
  end

  always_comb begin
    case (op)
      3'd0:    res = rot & mask;
      3'd1:    res = (dst_old & ~mask) | (rot & mask);
      3'd2:    res = amt[SW] ? '0 : src << sh;
      3'd3:    res = amt[SW] ? '0 : src >> sh;
      3'd4:    res = amt[SW] ? {W{src[W-1]}} : W'($signed(src) >>> sh);
      default: res = '0;
    endcase
  end

  assign res_neg  = res[W-1];
  assign res_zero = (res == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      cond_valid <= 1'b0;
      cond       <= '0;
    end else begin
      out_valid  <= in_valid;
      cond_valid <= in_valid & rec_en;
      if (in_valid) begin
        result <= res;
        cond   <= rec_en ? {res_neg, ~res_neg & ~res_zero, res_zero} : 3'b000;
      end
    end
  end
endmodule

// File: rtl/rms_unit_chk.sv
`timescale 1ns/1ps
module rms_unit_chk #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic [W-1:0]  src,
  input logic [SW:0]   amt,
  input logic [SW-1:0] mask_beg,
  input logic [SW-1:0] mask_end,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          cond_valid,
  input logic [2:0]    cond
);
  p_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result));
  p_sll_big_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd2 && amt[SW] |=> result == '0);
  p_srl_big_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd3 && amt[SW] |=> result == '0);
  p_sra_big_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd4 && amt[SW] |=> result == {W{$past(src[W-1])}});
  p_rot_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd0 && amt[SW-1:0] == '0 && mask_beg == '0 &&
    mask_end == SW'(W-1) |=> result == $past(src));
  p_cond_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> $countones(cond) == 1 && out_valid);
  p_cond_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid && result == '0 |-> cond == 3'b001);
  p_reset_r11: assert property (@(posedge clk)
    !rst_n |-> !out_valid && !cond_valid && result == '0);
endmodule

bind rms_unit rms_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src),
  .amt(amt), .mask_beg(mask_beg), .mask_end(mask_end),
  .out_valid(out_valid), .result(result), .cond_valid(cond_valid),
  .cond(cond)
);

// File: tb/rms_unit_tb.sv
`timescale 1ns/1ps
module rms_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src = '0, dst_old = '0;
  logic [5:0]  amt = '0;
  logic [4:0]  mask_beg = '0, mask_end = '0;
  logic        rec_en = 1'b0;
  logic        out_valid, cond_valid;
  logic [31:0] result;
  logic [2:0]  cond;

  int errors = 0, checks = 0;
  bit done = 0;

  logic        pend = 0, was_idle = 0, rec_pend = 0;
  logic [31:0] exp_res = '0, held = '0;
  string       tag_pend = "";

  always #2 clk = ~clk;

  rms_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src),
    .dst_old(dst_old), .amt(amt), .mask_beg(mask_beg), .mask_end(mask_end),
    .rec_en(rec_en), .out_valid(out_valid), .result(result),
    .cond_valid(cond_valid), .cond(cond)
  );

  function automatic logic [31:0] mk_mask(input int b, input int e);
    logic [31:0] ones = 32'hFFFF_FFFF;
    if (b <= e) return (ones >> b) & (ones << (31 - e));
    return (ones << (31 - e)) | (ones >> b);
  endfunction

  function automatic logic [31:0] rotl(input logic [31:0] v, input int s);
    if (s == 0) return v;
    return (v << s) | (v >> (32 - s));
  endfunction

  function automatic logic [31:0] model(input int o, input logic [31:0] s,
      input logic [31:0] d, input int a, input int b, input int e);
    logic [31:0] m = mk_mask(b, e);
    logic [31:0] r = rotl(s, a % 32);
    case (o)
      0: return r & m;
      1: return (d & ~m) | (r & m);
      2: return (a >= 32) ? 32'd0 : s << (a % 32);
      3: return (a >= 32) ? 32'd0 : s >> (a % 32);
      4: begin
        if (a >= 32) return s[31] ? 32'hFFFF_FFFF : 32'd0;
        return s[31] ? ((s >> a) | ~(32'hFFFF_FFFF >> a)) : (s >> a);
      end
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input int o, input logic [31:0] s,
      input logic [31:0] d, input int a, input int b, input int e,
      input bit rec, input string tag);
    logic [2:0] ec;
    @(negedge clk);
    if (pend) begin
      check(out_valid === 1'b1, "R9", {31'd0, out_valid}, 32'd1);
      check(result === exp_res, tag_pend, result, exp_res);
      check(cond_valid === rec_pend, "R10", {31'd0, cond_valid}, {31'd0, rec_pend});
      if (rec_pend) begin
        ec = $signed(exp_res) < 0 ? 3'b100 : (exp_res == 0 ? 3'b001 : 3'b010);
        check(cond === ec, "R10", {29'd0, cond}, {29'd0, ec});
      end
      held = exp_res;
    end else if (was_idle) begin
      check(out_valid === 1'b0 && result === held, "R9", result, held);
    end
    was_idle = !pend;
    in_valid = v; op = 3'(o); src = s; dst_old = d; amt = 6'(a);
    mask_beg = 5'(b); mask_end = 5'(e); rec_en = rec;
    pend = v; rec_pend = rec; tag_pend = tag;
    exp_res = model(o, s, d, a, b, e);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] vals [6];
    #9;
    // R11
    check(out_valid === 0 && cond_valid === 0 && result === 0 && cond === 0,
          "R11", result, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1, R2, R3, R4: every begin/end pair, back to back
    for (int b = 0; b < 32; b++)
      for (int e = 0; e < 32; e++) begin
        step(1, 0, $urandom, $urandom, $urandom % 64, b, e, ((b + e) % 3) == 0,
             b <= e ? "R1/R3" : "R2/R3");
        step(1, 1, $urandom, $urandom, $urandom % 64, b, e, ((b ^ e) & 1) == 1,
             "R4");
      end
    // R8: rotate by zero, full mask
    step(1, 0, 32'h8000_0001, 0, 0, 0, 31, 1, "R8");
    step(1, 0, 32'hDEAD_BEEF, 0, 32, 0, 31, 0, "R8");
    step(1, 1, 32'h1234_5678, 32'hFFFF_FFFF, 0, 0, 31, 1, "R8");
    // R5, R6, R7: every amount over edge and random sources
    vals[0] = 32'h8000_0000; vals[1] = 32'hFFFF_FFFF; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h0000_0001; vals[4] = $urandom | 32'h8000_0000; vals[5] = $urandom;
    for (int k = 0; k < 6; k++)
      for (int a = 0; a < 64; a++) begin
        step(1, 2, vals[k], 0, a, 0, 0, a[0], "R5");
        step(1, 3, vals[k], 0, a, 0, 0, a[1], "R6");
        step(1, 4, vals[k], 0, a, 0, 0, 1, "R7");
      end
    // R12
    for (int o = 5; o < 8; o++) step(1, o, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 0, 31, 1, "R12");
    // R9: idle cycles hold the result
    step(1, 0, 32'hA5A5_0F0F, 0, 4, 0, 31, 0, "R3");
    step(0, 0, 32'h1111_1111, 0, 0, 0, 31, 0, "R9");
    step(0, 2, 32'h2222_2222, 0, 1, 0, 31, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule